// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a simple synchronous request bus and an external asynchronous static RAM of 128K words by 16 bits, organised as two byte lanes. A client presents one read or write at a time, with a 17-bit word address, 16 bits of write data and one active-high strobe per byte. The controller turns each request into a timed sequence on the memory's active-low select, write, output and lane-enable pins. It also controls the shared data bus through separate drive, sample and drive-enable signals.

Access timing is set by the clock period and by the memory's access time, both in nanoseconds. From these two values the block derives the number of wait cycles. Before write enable falls, the controller spends one setup cycle presenting the address, lane enables and data. After write enable rises, it holds them for one more cycle. When the bus direction changes between two real accesses, it inserts one idle cycle. When no transfer is in progress, the memory is left deselected, which puts it in standby. A read returns its data with a one-cycle valid pulse, and a write or an empty request returns the same pulse with zero data.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the memory pins sit at standby: `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are all 1 and `mem_dq_oe` is 0.
- R2: A write with at least one strobe set passes through three phases. First comes one setup cycle (`mem_ce_n`=0, `mem_we_n`=1, data driven). Then come the wait cycles with `mem_we_n`=0. Last comes one hold cycle (`mem_we_n`=1, `mem_ce_n`=0, data still driven). Address, data and lane enables do not change from setup through hold. `req_be[0]` maps to `mem_lb_n` low and data bits 7:0, and `req_be[1]` maps to `mem_ub_n` low and data bits 15:8.
- R3: `mem_dq_oe` is 1 only during the setup, wait and hold cycles of a write. `mem_oe_n` is 1 in every cycle where `mem_dq_oe` is 1 or `mem_we_n` is 0.
- R4: A read passes through one setup cycle (`mem_ce_n`=0, `mem_oe_n`=1) and then the wait cycles with `mem_oe_n`=0. `mem_we_n` stays 1 throughout, and the lane enables follow the strobes as in R2.
- R5: Read data is sampled from `mem_dq_in` on the last wait cycle and shown on `rsp_rdata` in the following cycle. A lane whose strobe was 0 reads as 0. `rsp_rdata` is 0 for writes and for empty requests.
- R6: A request with `req_be`=2'b00 touches no memory pin: `mem_ce_n` stays 1, and `rsp_valid` is 1 in the cycle after acceptance.
- R7: One cycle with every memory control high and no drive comes between acceptance and setup when the request's direction differs from the last request that had a strobe set. Empty requests do not change the remembered direction.
- R8: `req_ready` is 0 from the cycle after acceptance through the cycle in which `rsp_valid` is 1, and it is 1 in the cycle after that.
- R9: `rsp_valid` is a single-cycle pulse, given exactly once for each accepted request.
- R10: The number of wait cycles is the access time divided by the clock period, rounded up. With the defaults (70 ns access, 4 ns clock) this gives 18 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte strobes, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, lanes not requested zeroed |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data sampled from the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is the turnaround decision when empty requests come between accesses. A write followed by an empty request and then a read must still insert the idle cycle. A read followed by an empty request and then another read must not. The stimulus therefore places strobe-less requests between reads and writes in both orders. It also runs a long mixed sequence in which direction, lane pattern and address change from one request to the next. The memory model returns a filler pattern on lanes that are not enabled, so a lane that fails to be zeroed shows up in the compared read data.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W        = 17,
  parameter int CLK_PERIOD_NS = 4,
  parameter int ACCESS_NS     = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [15:0]       mem_dq_out,
  input  logic [15:0]       mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int WAIT_CYC = (ACCESS_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int CNT_W    = $clog2(WAIT_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_ACCESS, ST_HOLD, ST_RESP
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic              wr_q, have_prev, prev_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q, rdata_q;
  logic [1:0]        be_q;

  wire accept  = req_valid && state == ST_IDLE;
  wire active  = state == ST_SETUP || state == ST_ACCESS || state == ST_HOLD;
  wire last_wt = state == ST_ACCESS && cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      have_prev <= 1'b0;
      prev_wr   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      be_q      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          rdata_q <= '0;
          if (req_be == 2'b00) begin
            state <= ST_RESP;
          end else begin
            have_prev <= 1'b1;
            prev_wr   <= req_write;
            state     <= (have_prev && prev_wr != req_write) ? ST_TURN : ST_SETUP;
          end
        end
        ST_TURN:  state <= ST_SETUP;
        ST_SETUP: begin
          cnt   <= CNT_W'(WAIT_CYC - 1);
          state <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (cnt == '0) begin
            if (wr_q) begin
              state <= ST_HOLD;
            end else begin
              rdata_q <= {be_q[1] ? mem_dq_in[15:8] : 8'h00,
                          be_q[0] ? mem_dq_in[7:0]  : 8'h00};
              state   <= ST_RESP;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD:  state <= ST_RESP;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = state == ST_IDLE;
  assign rsp_valid  = state == ST_RESP;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !active;
  assign mem_lb_n   = !(active && be_q[0]);
  assign mem_ub_n   = !(active && be_q[1]);
  assign mem_we_n   = !(state == ST_ACCESS && wr_q);
  assign mem_oe_n   = !(state == ST_ACCESS && !wr_q);
  assign mem_dq_oe  = active && wr_q;
  assign mem_dq_out = wdata_q;

  assert_standby_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

  assert_setup_before_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe) && $stable(mem_addr)
                         && $stable(mem_dq_out) && $stable(mem_ub_n) && $stable(mem_lb_n)));

  assert_hold_after_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr)
                         && $stable(mem_dq_out) && $stable(mem_ub_n) && $stable(mem_lb_n)));

  assert_no_drive_with_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe || !mem_we_n) |-> mem_oe_n);

  assert_read_no_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_ce_n));

  assert_noop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_be == 2'b00) |=> (mem_ce_n && rsp_valid));

  assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int W = 18;  // R10: ceil(70 ns / 4 ns)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (.*);

  logic [15:0] mem [int];
  int checks = 0, fails = 0, cycles = 0;
  bit run_mon = 1'b0;
  bit have_prev = 1'b0, prev_wr = 1'b0;

  function automatic logic [15:0] mem_rd(input logic [16:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[15:0] ^ 16'hC3A5 ^ {15'b0, a[16]};
  endfunction

  always_comb begin
    logic [15:0] m;
    m = mem_rd(mem_addr);
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = {!mem_ub_n ? m[15:8] : 8'hA5, !mem_lb_n ? m[7:0] : 8'hA5};
    else
      mem_dq_in = 16'h5A5A;
  end

  always @(posedge mem_we_n) if (!mem_ce_n && rst_n) begin
    logic [15:0] m;
    m = mem_rd(mem_addr);
    if (!mem_ub_n) m[15:8] = mem_dq_out[15:8];
    if (!mem_lb_n) m[7:0]  = mem_dq_out[7:0];
    mem[int'(mem_addr)] = m;
  end

  typedef struct packed {
    logic [3:0] tag;
    logic [5:0] ctl;   // ce_n we_n oe_n ub_n lb_n dq_oe
    logic       ready;
    logic       rsp;
    logic [16:0] addr;
    logic [15:0] wd;
    logic [15:0] rd;
  } exp_t;
  exp_t q[$];

  function automatic string tname(input logic [3:0] t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      9: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (run_mon) begin
    exp_t e;
    logic [5:0] act;
    if (q.size() > 0) e = q.pop_front();
    else e = '{tag: 4'd1, ctl: 6'b111110, ready: 1'b1, rsp: 1'b0, addr: '0, wd: '0, rd: '0};
    act = {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe};
    chk(act == e.ctl, tname(e.tag), "memory controls", 32'(act), 32'(e.ctl));
    chk(req_ready == e.ready, "R8", "req_ready", 32'(req_ready), 32'(e.ready));
    chk(rsp_valid == e.rsp, "R9", "rsp_valid", 32'(rsp_valid), 32'(e.rsp));
    if (!e.ctl[5]) chk(mem_addr == e.addr, "R2", "mem_addr", 32'(mem_addr), 32'(e.addr));
    if (e.ctl[0]) chk(mem_dq_out == e.wd, "R3", "mem_dq_out", 32'(mem_dq_out), 32'(e.wd));
    if (e.rsp) chk(rsp_rdata == e.rd, "R5", "rsp_rdata", 32'(rsp_rdata), 32'(e.rd));
  end

  task automatic push(input logic [3:0] tag, input logic [5:0] ctl, input logic rsp,
                      input logic [16:0] a, input logic [15:0] wd, input logic [15:0] rd);
    q.push_back('{tag: tag, ctl: ctl, ready: 1'b0, rsp: rsp, addr: a, wd: wd, rd: rd});
  endtask

  task automatic issue(input bit wr, input logic [16:0] a, input logic [1:0] be,
                       input logic [15:0] wd);
    logic [15:0] m, rd;
    logic [1:0] ln;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    @(posedge clk);
    m  = mem_rd(a);
    ln = ~be;
    rd = wr ? 16'h0 : {be[1] ? m[15:8] : 8'h00, be[0] ? m[7:0] : 8'h00};
    if (be == 2'b00) begin
      push(4'd6, 6'b111110, 1'b1, a, wd, 16'h0);
    end else begin
      if (have_prev && prev_wr != wr) push(4'd7, 6'b111110, 1'b0, a, wd, 0);
      have_prev = 1'b1; prev_wr = wr;
      push(wr ? 4'd2 : 4'd4, {3'b011, ln, wr}, 1'b0, a, wd, 0);
      for (int i = 0; i < W; i++)
        push(4'd10, {1'b0, !wr, wr, ln, wr}, 1'b0, a, wd, 0);
      if (wr) push(4'd2, {3'b011, ln, 1'b1}, 1'b0, a, wd, 0);
      push(4'd5, 6'b111110, 1'b1, a, wd, rd);
    end
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~wd;
    while (q.size() > 0) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run_mon = 1'b1;                               // R1 reset state checked by monitor
    repeat (2) @(negedge clk);
    issue(1'b1, 17'h00010, 2'b11, 16'hBEEF);       // R2 full write
    issue(1'b1, 17'h00011, 2'b11, 16'h1234);       // R2 back-to-back, no turn
    issue(1'b0, 17'h00010, 2'b11, 16'h0);          // R7 turn, R4 read
    issue(1'b0, 17'h00011, 2'b01, 16'h0);          // R5 upper lane zero
    issue(1'b0, 17'h00011, 2'b10, 16'h0);          // R5 lower lane zero
    issue(1'b1, 17'h00010, 2'b10, 16'hA100);       // R2 upper only
    issue(1'b0, 17'h00010, 2'b11, 16'h0);          // R2 lower preserved
    issue(1'b1, 17'h1FFFF, 2'b01, 16'h00C7);       // top address
    issue(1'b0, 17'h00000, 2'b11, 16'h0);          // address zero
    issue(1'b1, 17'h00020, 2'b00, 16'hFFFF);       // R6 no-op after read
    issue(1'b0, 17'h00021, 2'b11, 16'h0);          // R7 no turn: last real was read
    issue(1'b1, 17'h00022, 2'b11, 16'h5555);       // R7 turn
    issue(1'b0, 17'h00022, 2'b00, 16'h0);          // R6 no-op
    issue(1'b0, 17'h00022, 2'b11, 16'h0);          // R7 turn across no-op
    issue(1'b0, 17'h1FFFF, 2'b11, 16'h0);
    for (int i = 0; i < 40; i++) begin
      logic [16:0] a;
      a = 17'((i * 7919) % 24);
      issue(((i * 5) % 3) != 0, a, 2'(i * 3), 16'(i * 16'h3B1D + 16'h0F0F));
    end
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule